// File: doc/BRIEF.md
# Interrupt Pending-State Tracker

This block keeps the per-line state of a small group of interrupt inputs and tells a single CPU interface which one to service. For every line it records the sampled input level, a pending flag, an active flag, an enable flag and a trigger mode (edge or level). Software-style configuration inputs load the enable and trigger masks. The CPU interface acknowledges the reported line and later signals end-of-interrupt by line number.

Pending and enable are independent. An input transition sets pending whether or not the line is enabled. Enable only decides whether a pending line may be offered as a request. An instance parameter selects between two ways of handling level-triggered lines. In the split mode a level line may be pending and active together. In the exclusive mode such a line is never both at once, and it is re-pended when its handling completes while the input is still asserted.

Top module: `irq_pend_tracker`

## Requirements
- R1: A rising input (sampled high after being low in the previous cycle) sets the line's pending flag in the next cycle, whether or not the line is enabled. Exclusive mode adds the restriction in R8.
- R2: When the input falls, a level-triggered line clears its pending flag. An edge-triggered line keeps its pending flag. In `cfg_edge`, bit value 1 means edge and 0 means level.
- R3: `req` is high when at least one line is pending, enabled and not active. `req_id` is the lowest-numbered such line. When no line qualifies, `req` is low and `req_id` equals NUM_LINES (8 by default).
- R4: `req`, `req_id`, `pend_o` and `active_o` reflect an input or strobe in the first cycle after the clock edge that samples it.
- R5: `ack` while `req` is high makes line `req_id` active and clears its pending flag, except where R7 applies. `ack` while `req` is low changes nothing.
- R6: `eoi` clears the active flag of line `eoi_id`. An `eoi_id` of NUM_LINES or more changes nothing.
- R7: In split mode (default), a level-triggered line whose input stays high remains pending through its acknowledge. It is therefore requested again as soon as its end-of-interrupt clears the active flag.
- R8: In exclusive mode, a rising input sets pending only if the line is edge-triggered or not active. A level-triggered line is never pending and active at once.
- R9: In exclusive mode, an end-of-interrupt for an active level-triggered line whose input is high makes it pending. If its input is low, it becomes idle.
- R10: Synchronous active-low reset clears all pending, active, enable and recorded-level state and makes every line level-triggered.
- R11: `cfg_we` loads `cfg_enable` (1 = enabled) and `cfg_edge` into the line configuration at the clock edge. The new values govern from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Interrupt inputs, synchronous to clk |
| cfg_we | input | 1 | Load enable and trigger masks |
| cfg_enable | input | NUM_LINES | Enable mask, 1 = forward when pending |
| cfg_edge | input | NUM_LINES | Trigger mask, 1 = edge, 0 = level |
| ack | input | 1 | Acknowledge the currently reported line |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | IDW | Line number completed by `eoi` |
| req | output | 1 | Request to the CPU interface |
| req_id | output | IDW | Chosen line, NUM_LINES when none |
| pend_o | output | NUM_LINES | Pending flags |
| active_o | output | NUM_LINES | Active flags |

## Verification
A wrong pending flag shows on `pend_o` one cycle after the edge that produced it. If the line is enabled and idle, it also shows on `req`/`req_id` in that same cycle, for example a lost edge, a cleared edge-line flag or a level line that fails to re-pend. A wrong active flag shows up as a line that is never re-requested, or one requested while it is still being serviced. It is visible on `active_o` in the cycle after the `ack` or `eoi`. The two level-line modes are told apart by the pending and active pattern right after an acknowledge while the input is held high, and right after the end-of-interrupt that follows.

// File: rtl/irq_trk_pkg.sv
// Shared types for the interrupt pending-state tracker.
package irq_trk_pkg;

    // Pending semantics for level-triggered lines.
    //   SEM_SPLIT : pending follows the input, so pending and active may coexist
    //   SEM_EXCL  : pending and active are exclusive, re-pend at completion
    typedef enum logic {
        SEM_SPLIT = 1'b0,
        SEM_EXCL  = 1'b1
    } pend_sem_e;

    // Trigger mode bit encoding in the configuration mask.
    localparam logic TRIG_LEVEL = 1'b0;
    localparam logic TRIG_EDGE  = 1'b1;

endpackage

// File: rtl/irq_line_cell.sv
// irq_line_cell: state of one interrupt line.
// Holds the recorded input level, pending, active, enable and trigger mode.
// Assumes irq_in is synchronous to clk. ack_hit is asserted only for a line
// that is pending, enabled and not active. eoi_hit may target any line.
module irq_line_cell
    import irq_trk_pkg::*;
#(
    parameter pend_sem_e SEM = SEM_SPLIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic cfg_we,
    input  logic cfg_en,
    input  logic cfg_edge,
    input  logic ack_hit,
    input  logic eoi_hit,
    output logic pend_q,
    output logic act_q,
    output logic en_q,
    output logic trig_edge_q
);

    logic level_q;
    logic rise;
    logic fall;
    logic pend_n;
    logic act_n;

    // Transition detection against the level recorded in the previous cycle.
    assign rise = irq_in & ~level_q;
    assign fall = ~irq_in & level_q;

    // Next pending state: clears first, sets afterwards so that a new event wins.
    always_comb begin
        pend_n = pend_q;
        if (ack_hit) begin
            pend_n = 1'b0;
        end
        if (fall && (trig_edge_q == TRIG_LEVEL)) begin
            pend_n = 1'b0;
        end
        if (SEM == SEM_SPLIT) begin
            if (rise || (irq_in && (trig_edge_q == TRIG_LEVEL))) begin
                pend_n = 1'b1;
            end
        end else begin
            if (rise && ((trig_edge_q == TRIG_EDGE) || !act_q)) begin
                pend_n = 1'b1;
            end
            if (eoi_hit && act_q && (trig_edge_q == TRIG_LEVEL) && irq_in) begin
                pend_n = 1'b1;
            end
        end
    end

    // Next active state: completion clears, acknowledge sets.
    always_comb begin
        act_n = act_q;
        if (eoi_hit) begin
            act_n = 1'b0;
        end
        if (ack_hit) begin
            act_n = 1'b1;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q     <= 1'b0;
            pend_q      <= 1'b0;
            act_q       <= 1'b0;
            en_q        <= 1'b0;
            trig_edge_q <= TRIG_LEVEL;
        end else begin
            level_q <= irq_in;
            pend_q  <= pend_n;
            act_q   <= act_n;
            if (cfg_we) begin
                en_q        <= cfg_en;
                trig_edge_q <= cfg_edge;
            end
        end
    end

    // R1: an allowed rising input leaves the line pending.
    p_rise_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && ((SEM == SEM_SPLIT) || trig_edge_q || !act_q)) |=> pend_q);

    // R2: a falling level-triggered line is no longer pending.
    p_fall_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !trig_edge_q) |=> !pend_q);

    // R2: a falling edge-triggered line keeps its pending flag.
    p_edge_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && trig_edge_q && !ack_hit) |=> (pend_q == $past(pend_q)));

    // R2: the recorded level follows the input one cycle later.
    p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (level_q == $past(irq_in)));

    generate
        if (SEM == SEM_EXCL) begin : g_excl_chk
            // R8: a level-triggered line is never pending and active together.
            p_excl_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !trig_edge_q |-> !(pend_q && act_q));

            // R9: completing a still-high level line re-pends it.
            p_repend_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (eoi_hit && act_q && !trig_edge_q && irq_in) |=> (pend_q && !act_q));
        end
    endgenerate

endmodule

// File: rtl/irq_pick.sv
// irq_pick: fixed-order selector.
// Reports the lowest-numbered set bit of cand. When cand is zero, it reports
// NUM_LINES as the "none" identifier. Purely combinational.
module irq_pick #(
    parameter int NUM_LINES = 8,
    parameter int IDW       = 4
) (
    input  logic [NUM_LINES-1:0] cand,
    output logic                 valid,
    output logic [IDW-1:0]       id
);

    // Scan from the top down so the lowest candidate is written last.
    always_comb begin
        valid = 1'b0;
        id    = IDW'(NUM_LINES);
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                valid = 1'b1;
                id    = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_pend_tracker.sv
// irq_pend_tracker: pending and active state for NUM_LINES interrupt lines
// serving one CPU interface. Builds one irq_line_cell per line, forms the
// candidate set (pending, enabled, not active) and reports the lowest one.
// Assumes all inputs are synchronous to clk. ack acts on the line reported in
// the same cycle. SEM picks the level-line pending semantics for this instance.
module irq_pend_tracker
    import irq_trk_pkg::*;
#(
    parameter int        NUM_LINES = 8,
    parameter pend_sem_e SEM       = SEM_SPLIT,
    localparam int       IDW       = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic [NUM_LINES-1:0] cfg_enable,
    input  logic [NUM_LINES-1:0] cfg_edge,
    input  logic                 ack,
    input  logic                 eoi,
    input  logic [IDW-1:0]       eoi_id,
    output logic                 req,
    output logic [IDW-1:0]       req_id,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] active_o
);

    localparam logic [IDW-1:0] NONE_ID = IDW'(NUM_LINES);

    logic [NUM_LINES-1:0] pend_v;
    logic [NUM_LINES-1:0] act_v;
    logic [NUM_LINES-1:0] en_v;
    logic [NUM_LINES-1:0] trig_v;
    logic [NUM_LINES-1:0] cand;
    logic [NUM_LINES-1:0] ack_hit;
    logic [NUM_LINES-1:0] eoi_hit;
    logic                 pick_valid;
    logic [IDW-1:0]       pick_id;

    // Lines eligible for forwarding: enable gates only this, never pending.
    assign cand = pend_v & en_v & ~act_v;

    // Lowest-numbered eligible line.
    irq_pick #(
        .NUM_LINES (NUM_LINES),
        .IDW       (IDW)
    ) u_pick (
        .cand  (cand),
        .valid (pick_valid),
        .id    (pick_id)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            // Strobe decode for this line.
            assign ack_hit[g] = ack && pick_valid && (pick_id == IDW'(g));
            assign eoi_hit[g] = eoi && (eoi_id == IDW'(g));

            irq_line_cell #(
                .SEM (SEM)
            ) u_cell (
                .clk         (clk),
                .rst_n       (rst_n),
                .irq_in      (irq_in[g]),
                .cfg_we      (cfg_we),
                .cfg_en      (cfg_enable[g]),
                .cfg_edge    (cfg_edge[g]),
                .ack_hit     (ack_hit[g]),
                .eoi_hit     (eoi_hit[g]),
                .pend_q      (pend_v[g]),
                .act_q       (act_v[g]),
                .en_q        (en_v[g]),
                .trig_edge_q (trig_v[g])
            );
        end
    endgenerate

    assign req      = pick_valid;
    assign req_id   = pick_id;
    assign pend_o   = pend_v;
    assign active_o = act_v;

    // R5: an acknowledged line is active in the next cycle.
    p_ack_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_hit) |=> ((act_v & $past(ack_hit)) == $past(ack_hit)));

    // R5: at most one line is acknowledged per cycle.
    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));

    // R6: a completed line is inactive next cycle unless it was acknowledged too.
    p_eoi_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(eoi_hit & ~ack_hit)) |=> ((act_v & $past(eoi_hit & ~ack_hit)) == '0));

    // R3: with no request the reported identifier is the "none" value.
    p_none_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (req_id == NONE_ID));

    // R10: the cycle after reset nothing is pending, active or requested.
    p_reset_idle_r10: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (pend_v == '0 && act_v == '0 && !req));

    // R11: a configured-off line is never offered as the request.
    p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_v == '0) |-> !req);

    // Trigger mask is only consumed inside the cells; keep it observable here.
    p_trig_reset_r10: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (trig_v == '0));

endmodule

// File: tb/tb_irq_pend_tracker.sv
`timescale 1ns/100ps
module tb_irq_pend_tracker;
    import irq_trk_pkg::*;

    localparam int N   = 8;
    localparam int IDW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Split-mode instance inputs/outputs.
    logic [N-1:0] d_irq = '0, d_en = '0, d_edg = '0;
    logic d_we = 1'b0, d_ack = 1'b0, d_eoi = 1'b0;
    logic [IDW-1:0] d_eid = '0;
    logic d_req; logic [IDW-1:0] d_rid; logic [N-1:0] d_pend, d_act;

    // Exclusive-mode instance inputs/outputs.
    logic [N-1:0] a_irq = '0, a_en = '0, a_edg = '0;
    logic a_we = 1'b0, a_ack = 1'b0, a_eoi = 1'b0;
    logic [IDW-1:0] a_eid = '0;
    logic a_req; logic [IDW-1:0] a_rid; logic [N-1:0] a_pend, a_act;

    irq_pend_tracker #(.NUM_LINES(N), .SEM(SEM_SPLIT)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(d_irq), .cfg_we(d_we),
        .cfg_enable(d_en), .cfg_edge(d_edg), .ack(d_ack), .eoi(d_eoi),
        .eoi_id(d_eid), .req(d_req), .req_id(d_rid), .pend_o(d_pend),
        .active_o(d_act));

    irq_pend_tracker #(.NUM_LINES(N), .SEM(SEM_EXCL)) dut_alt (
        .clk(clk), .rst_n(rst_n), .irq_in(a_irq), .cfg_we(a_we),
        .cfg_enable(a_en), .cfg_edge(a_edg), .ack(a_ack), .eoi(a_eoi),
        .eoi_id(a_eid), .req(a_req), .req_id(a_rid), .pend_o(a_pend),
        .active_o(a_act));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [7:0] irq; logic we; logic [7:0] en; logic [7:0] edg;
        logic ack; logic eoi; logic [3:0] eid;
        logic xreq; logic [3:0] xid; logic [7:0] xpend; logic [7:0] xact;
    } vec_t;

    // Split-mode table; each row's outputs are checked one cycle after drive (R4).
    localparam vec_t TBL [13] = '{
        '{8'h00,1'b1,8'h0F,8'h02,1'b0,1'b0,4'd0, 1'b0,4'd8,8'h00,8'h00}, // R11 config
        '{8'h10,1'b0,8'h00,8'h00,1'b0,1'b0,4'd0, 1'b0,4'd8,8'h10,8'h00}, // R1 disabled line pends
        '{8'h12,1'b0,8'h00,8'h00,1'b0,1'b0,4'd0, 1'b1,4'd1,8'h12,8'h00}, // R3 edge line requested
        '{8'h10,1'b0,8'h00,8'h00,1'b0,1'b0,4'd0, 1'b1,4'd1,8'h12,8'h00}, // R2 edge keeps pending
        '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,4'd0, 1'b1,4'd1,8'h02,8'h00}, // R2 level clears
        '{8'h00,1'b0,8'h00,8'h00,1'b1,1'b0,4'd0, 1'b0,4'd8,8'h00,8'h02}, // R5 ack
        '{8'h01,1'b0,8'h00,8'h00,1'b0,1'b0,4'd0, 1'b1,4'd0,8'h01,8'h02}, // R3 lowest idle line
        '{8'h01,1'b0,8'h00,8'h00,1'b1,1'b0,4'd0, 1'b0,4'd8,8'h01,8'h03}, // R7 pend+active
        '{8'h01,1'b0,8'h00,8'h00,1'b0,1'b1,4'd0, 1'b1,4'd0,8'h01,8'h02}, // R7 re-request
        '{8'h01,1'b0,8'h00,8'h00,1'b0,1'b1,4'd1, 1'b1,4'd0,8'h01,8'h00}, // R6 eoi line 1
        '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,4'd0, 1'b0,4'd8,8'h00,8'h00}, // R2 level drop
        '{8'h02,1'b1,8'h00,8'h02,1'b0,1'b0,4'd0, 1'b0,4'd8,8'h02,8'h00}, // R3 disable gates req
        '{8'h02,1'b1,8'h02,8'h02,1'b0,1'b0,4'd0, 1'b1,4'd1,8'h02,8'h00}  // R11 re-enable
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_d(input string tag, input logic xr, input logic [3:0] xi,
                            input logic [7:0] xp, input logic [7:0] xa);
        chk(tag, "split req", 32'(d_req), 32'(xr));
        chk(tag, "split req_id", 32'(d_rid), 32'(xi));
        chk(tag, "split pend", 32'(d_pend), 32'(xp));
        chk(tag, "split active", 32'(d_act), 32'(xa));
    endtask

    task automatic expect_a(input string tag, input logic xr, input logic [3:0] xi,
                            input logic [7:0] xp, input logic [7:0] xa);
        chk(tag, "excl req", 32'(a_req), 32'(xr));
        chk(tag, "excl req_id", 32'(a_rid), 32'(xi));
        chk(tag, "excl pend", 32'(a_pend), 32'(xp));
        chk(tag, "excl active", 32'(a_act), 32'(xa));
    endtask

    // Drive the split instance for one cycle; returns at the next falling edge.
    task automatic step_d(input logic [7:0] irq, input logic we, input logic [7:0] en,
                          input logic [7:0] edg, input logic ack, input logic eoi,
                          input logic [3:0] eid);
        d_irq = irq; d_we = we; d_en = en; d_edg = edg;
        d_ack = ack; d_eoi = eoi; d_eid = eid;
        @(negedge clk);
        d_we = 1'b0; d_ack = 1'b0; d_eoi = 1'b0;
    endtask

    task automatic step_a(input logic [7:0] irq, input logic we, input logic [7:0] en,
                          input logic [7:0] edg, input logic ack, input logic eoi,
                          input logic [3:0] eid);
        a_irq = irq; a_we = we; a_en = en; a_edg = edg;
        a_ack = ack; a_eoi = eoi; a_eid = eid;
        @(negedge clk);
        a_we = 1'b0; a_ack = 1'b0; a_eoi = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10: reset state on both instances.
        expect_d("R10", 1'b0, 4'd8, 8'h00, 8'h00);
        expect_a("R10", 1'b0, 4'd8, 8'h00, 8'h00);

        // Table walk, split mode (R1 R2 R3 R4 R5 R6 R7 R11).
        for (int k = 0; k < 13; k++) begin
            step_d(TBL[k].irq, TBL[k].we, TBL[k].en, TBL[k].edg,
                   TBL[k].ack, TBL[k].eoi, TBL[k].eid);
            expect_d($sformatf("R4 row %0d", k), TBL[k].xreq, TBL[k].xid,
                     TBL[k].xpend, TBL[k].xact);
        end

        // R5: acknowledge without a request changes nothing.
        step_d(8'h02, 1'b1, 8'h00, 8'h02, 1'b0, 1'b0, 4'd0);
        step_d(8'h02, 1'b0, 8'h00, 8'h02, 1'b1, 1'b0, 4'd0);
        expect_d("R5 idle ack", 1'b0, 4'd8, 8'h02, 8'h00);

        // R6: out-of-range end-of-interrupt is ignored.
        step_d(8'h02, 1'b1, 8'h02, 8'h02, 1'b0, 1'b0, 4'd0);
        step_d(8'h02, 1'b0, 8'h02, 8'h02, 1'b1, 1'b0, 4'd0);
        expect_d("R5 ack edge", 1'b0, 4'd8, 8'h00, 8'h02);
        step_d(8'h02, 1'b0, 8'h02, 8'h02, 1'b0, 1'b1, 4'd15);
        expect_d("R6 bad id", 1'b0, 4'd8, 8'h00, 8'h02);
        step_d(8'h02, 1'b0, 8'h02, 8'h02, 1'b0, 1'b1, 4'd8);
        expect_d("R6 id N", 1'b0, 4'd8, 8'h00, 8'h02);

        // R10: reset mid-run clears state and restores level triggering.
        d_irq = 8'h00;
        do_reset();
        expect_d("R10 mid-run", 1'b0, 4'd8, 8'h00, 8'h00);
        step_d(8'h20, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0);
        expect_d("R1 after reset", 1'b0, 4'd8, 8'h20, 8'h00);
        step_d(8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0);
        expect_d("R10 level default", 1'b0, 4'd8, 8'h00, 8'h00);

        // Exclusive mode, level line 0 and edge line 1.
        step_a(8'h00, 1'b1, 8'h03, 8'h02, 1'b0, 1'b0, 4'd0);
        expect_a("R11 excl cfg", 1'b0, 4'd8, 8'h00, 8'h00);
        step_a(8'h01, 1'b0, 8'h03, 8'h02, 1'b0, 1'b0, 4'd0);
        expect_a("R1 excl rise", 1'b1, 4'd0, 8'h01, 8'h00);
        step_a(8'h01, 1'b0, 8'h03, 8'h02, 1'b1, 1'b0, 4'd0);
        expect_a("R8 ack exclusive", 1'b0, 4'd8, 8'h00, 8'h01);
        step_a(8'h00, 1'b0, 8'h03, 8'h02, 1'b0, 1'b0, 4'd0);
        expect_a("R8 drop", 1'b0, 4'd8, 8'h00, 8'h01);
        step_a(8'h01, 1'b0, 8'h03, 8'h02, 1'b0, 1'b0, 4'd0);
        expect_a("R8 rise while active", 1'b0, 4'd8, 8'h00, 8'h01);
        step_a(8'h01, 1'b0, 8'h03, 8'h02, 1'b0, 1'b1, 4'd0);
        expect_a("R9 repend high", 1'b1, 4'd0, 8'h01, 8'h00);
        step_a(8'h01, 1'b0, 8'h03, 8'h02, 1'b1, 1'b0, 4'd0);
        expect_a("R8 second ack", 1'b0, 4'd8, 8'h00, 8'h01);
        step_a(8'h00, 1'b0, 8'h03, 8'h02, 1'b0, 1'b1, 4'd0);
        expect_a("R9 low completes", 1'b0, 4'd8, 8'h00, 8'h00);
        step_a(8'h02, 1'b0, 8'h03, 8'h02, 1'b0, 1'b0, 4'd0);
        expect_a("R1 excl edge", 1'b1, 4'd1, 8'h02, 8'h00);
        step_a(8'h02, 1'b0, 8'h03, 8'h02, 1'b1, 1'b0, 4'd0);
        expect_a("R5 excl ack", 1'b0, 4'd8, 8'h00, 8'h02);
        step_a(8'h00, 1'b0, 8'h03, 8'h02, 1'b0, 1'b0, 4'd0);
        expect_a("R2 excl edge fall", 1'b0, 4'd8, 8'h00, 8'h02);
        step_a(8'h02, 1'b0, 8'h03, 8'h02, 1'b0, 1'b0, 4'd0);
        expect_a("R8 edge pends while active", 1'b0, 4'd8, 8'h02, 8'h02);
        step_a(8'h02, 1'b0, 8'h03, 8'h02, 1'b0, 1'b1, 4'd1);
        expect_a("R6 excl eoi", 1'b1, 4'd1, 8'h02, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule